// File: doc/BRIEF.md
# Peripheral Handshake DMA Engine

This block moves data between an external device and an on-chip memory buffer with no processor work per word. Software sets up a transfer window and a few mode bits through a small register port. The engine then raises a request line, and the peripheral paces every word with its own active-low strobes on a shared 16-bit parallel bus.

The transfer window has a 32-bit first address and a 32-bit last address. Each is split into a low half and a high half, and all four halves must be written before the run is enabled. Every strobe moves one word, either 8 or 16 bits wide. The engine writes the word into the memory port or reads it from there, then steps its address. After the word at the last address has moved, the run stops, the enable bit drops by itself, and an optional interrupt flag is raised.

The memory port reads combinationally: the memory must return the word at `mem_addr` within the same cycle.

Top module: `pdma_engine`

## Requirements
- R1: Register index 0 is the control word. Its bits are: bit 0 run enable; bit 1 direction (0 moves peripheral to memory, 1 moves memory to peripheral); bit 2 width (1 = 16-bit, 0 = 8-bit); bit 3 interrupt enable; bit 4 write-1-to-clear of the pending interrupt, which reads as 0; bit 5 interrupt pending, which is read-only. Indices 1, 2, 3 and 4 hold the first address low half, first address high half, last address low half and last address high half, and they read back what was written. All registers reset to zero.
- R2: `per_req` is high only while the run is enabled, the engine is waiting for a strobe, and no strobe is being serviced. It is low after reset and whenever the run is disabled.
- R3: In direction 0, `per_wr_n` going low while `per_req` is high causes one memory write in that same cycle. The write carries the bus word and goes to the current address.
- R4: In direction 1, `per_rd_n` going low while `per_req` is high causes one memory read at the current address in that same cycle. The read word appears on `per_dout` from the next cycle, with `per_oe` high until the strobe is released.
- R5: Each strobe produces exactly one transfer, however long it is held. `per_req` drops in the cycle after the transfer and rises again only after both strobes are high.
- R6: The first transfer uses the first address. Each later one uses the previous address plus 2 in 16-bit mode, or plus 1 in 8-bit mode.
- R7: The run ends when a strobe is released after the transfer at an address equal to or above the last address. At that point the enable bit clears itself and `per_req` stays low.
- R8: When a run ends with interrupt enable set, `irq` rises and stays high until a control write with bit 4 set. When a run ends with interrupt enable clear, `irq` stays low.
- R9: In 8-bit mode only bus bits 7:0 are carried. Bits 15:8 of the memory write data and of `per_dout` are zero.
- R10: A strobe is ignored while the run is disabled, and a strobe of the wrong kind for the programmed direction is ignored. Neither causes a memory access or changes the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data, combinational on cfg_addr |
| per_req | output | 1 | Request to the peripheral |
| per_wr_n | input | 1 | Peripheral write strobe, active low |
| per_rd_n | input | 1 | Peripheral read strobe, active low |
| per_din | input | 16 | Bus data from the peripheral |
| per_dout | output | 16 | Bus data to the peripheral |
| per_oe | output | 1 | Drive enable for per_dout |
| mem_addr | output | 32 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle |
| irq | output | 1 | Completion interrupt, level |

## Verification
The assertions check every cycle that:
- each access is a single-cycle pulse;
- the request falls after each access;
- no access occurs while the run is disabled;
- the upper byte stays zero in narrow mode;
- the interrupt rises only with its enable set;
- a finished run clears its enable.

Only the bench scenarios can show the rest:
- the address sequence for both widths;
- the exact data moved in each direction;
- the point at which the window ends;
- the write-to-clear behaviour of the pending flag;
- that wrong-kind strobes leave a later transfer on the expected address.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READY = 2'd1,
      ST_HOLD  = 2'd2
   } pdma_state_t;

   typedef struct packed {
      logic irq_en;
      logic wide;
      logic dir;
      logic en;
   } pdma_ctrl_t;

   localparam int CTRL_EN_BIT    = 0;
   localparam int CTRL_DIR_BIT   = 1;
   localparam int CTRL_WIDE_BIT  = 2;
   localparam int CTRL_IRQEN_BIT = 3;
   localparam int CTRL_CLR_BIT   = 4;
   localparam int CTRL_PEND_BIT  = 5;

endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
   import pdma_pkg::*;
#(
   parameter int REG_W  = 16,
   parameter int ADDR_W = 32,
   parameter int CFG_AW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic              done,
   output pdma_ctrl_t        ctrl,
   output logic [ADDR_W-1:0] start_addr,
   output logic [ADDR_W-1:0] stop_addr,
   output logic              irq
);

   localparam int PARTS = ADDR_W / REG_W;

   if (ADDR_W % REG_W != 0) begin : g_bad_split
      $error("pdma_regs: ADDR_W must be a multiple of REG_W");
   end
   if ((2 * PARTS + 1) > (1 << CFG_AW)) begin : g_bad_cfg
      $error("pdma_regs: CFG_AW too small for the register count");
   end
   if (REG_W <= CTRL_PEND_BIT) begin : g_bad_regw
      $error("pdma_regs: REG_W too narrow for the control word");
   end

   logic [REG_W-1:0] start_q [PARTS];
   logic [REG_W-1:0] stop_q  [PARTS];
   pdma_ctrl_t       ctrl_q;
   logic             pend_q;
   logic             ctrl_sel;
   logic             unused_wdata;

   assign ctrl_sel     = cfg_wr && (cfg_addr == CFG_AW'(0));
   assign unused_wdata = ^cfg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (ctrl_sel) begin
            ctrl_q.en     <= cfg_wdata[CTRL_EN_BIT];
            ctrl_q.dir    <= cfg_wdata[CTRL_DIR_BIT];
            ctrl_q.wide   <= cfg_wdata[CTRL_WIDE_BIT];
            ctrl_q.irq_en <= cfg_wdata[CTRL_IRQEN_BIT];
         end
         if (done) begin
            ctrl_q.en <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (done && ctrl_q.irq_en) begin
         pend_q <= 1'b1;
      end else if (ctrl_sel && cfg_wdata[CTRL_CLR_BIT]) begin
         pend_q <= 1'b0;
      end
   end

   for (genvar p = 0; p < PARTS; p++) begin : g_part
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            start_q[p] <= '0;
         end else if (cfg_wr && (cfg_addr == CFG_AW'(1 + p))) begin
            start_q[p] <= cfg_wdata;
         end
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stop_q[p] <= '0;
         end else if (cfg_wr && (cfg_addr == CFG_AW'(1 + PARTS + p))) begin
            stop_q[p] <= cfg_wdata;
         end
      end
      assign start_addr[p*REG_W +: REG_W] = start_q[p];
      assign stop_addr[p*REG_W +: REG_W]  = stop_q[p];
   end

   always_comb begin
      cfg_rdata = '0;
      if (cfg_addr == CFG_AW'(0)) begin
         cfg_rdata[CTRL_EN_BIT]    = ctrl_q.en;
         cfg_rdata[CTRL_DIR_BIT]   = ctrl_q.dir;
         cfg_rdata[CTRL_WIDE_BIT]  = ctrl_q.wide;
         cfg_rdata[CTRL_IRQEN_BIT] = ctrl_q.irq_en;
         cfg_rdata[CTRL_PEND_BIT]  = pend_q;
      end
      for (int p = 0; p < PARTS; p++) begin
         if (cfg_addr == CFG_AW'(1 + p))         cfg_rdata = start_q[p];
         if (cfg_addr == CFG_AW'(1 + PARTS + p)) cfg_rdata = stop_q[p];
      end
   end

   assign ctrl = ctrl_q;
   assign irq  = pend_q;

   // R8: pending only rises at the end of a run that had interrupts enabled
   assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(ctrl_q.irq_en) && $past(done));

endmodule

// File: rtl/pdma_addr_ctr.sv
module pdma_addr_ctr #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   input  logic              wide,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [ADDR_W-1:0] stop_addr,
   output logic [ADDR_W-1:0] addr,
   output logic              last
);

   if (ADDR_W < 2) begin : g_bad_aw
      $error("pdma_addr_ctr: ADDR_W must be at least 2");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] step;

   assign step = wide ? ADDR_W'(2) : ADDR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load) begin
         addr_q <= start_addr;
      end else if (advance) begin
         addr_q <= addr_q + step;
      end
   end

   assign addr = addr_q;
   assign last = (addr_q >= stop_addr);

   // R6: the counter never loads and advances in the same cycle
   assert_no_load_adv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && advance));

endmodule

// File: rtl/pdma_hs_fsm.sv
module pdma_hs_fsm
   import pdma_pkg::*;
#(
   parameter int BUS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             dir,
   input  logic             wide,
   input  logic             last,
   input  logic             wr_n,
   input  logic             rd_n,
   input  logic [BUS_W-1:0] din,
   input  logic [BUS_W-1:0] mem_rdata,
   output logic             req,
   output logic             load,
   output logic             advance,
   output logic             done,
   output logic             mem_we,
   output logic             mem_re,
   output logic [BUS_W-1:0] mem_wdata,
   output logic [BUS_W-1:0] dout,
   output logic             oe
);

   localparam int LOW_W = BUS_W / 2;

   if (BUS_W % 2 != 0 || BUS_W < 2) begin : g_bad_bus
      $error("pdma_hs_fsm: BUS_W must be even and at least 2");
   end

   pdma_state_t      st_q, st_d;
   logic [BUS_W-1:0] lane_mask;
   logic [BUS_W-1:0] dout_q;
   logic             take_wr, take_rd, released;

   for (genvar i = 0; i < BUS_W; i++) begin : g_lane
      if (i < LOW_W) begin : g_low
         assign lane_mask[i] = 1'b1;
      end else begin : g_high
         assign lane_mask[i] = wide;
      end
   end

   assign take_wr  = (st_q == ST_READY) && en && !dir && !wr_n;
   assign take_rd  = (st_q == ST_READY) && en &&  dir && !rd_n;
   assign released = wr_n && rd_n;

   always_comb begin
      st_d    = st_q;
      load    = 1'b0;
      advance = 1'b0;
      done    = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (en) begin
               load = 1'b1;
               st_d = ST_READY;
            end
         end
         ST_READY: begin
            if (!en)                  st_d = ST_IDLE;
            else if (take_wr || take_rd) st_d = ST_HOLD;
         end
         ST_HOLD: begin
            if (released) begin
               if (!en) begin
                  st_d = ST_IDLE;
               end else if (last) begin
                  done = 1'b1;
                  st_d = ST_IDLE;
               end else begin
                  advance = 1'b1;
                  st_d    = ST_READY;
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dout_q <= '0;
      else if (take_rd) dout_q <= mem_rdata & lane_mask;
   end

   assign req       = (st_q == ST_READY) && en;
   assign mem_we    = take_wr;
   assign mem_re    = take_rd;
   assign mem_wdata = din & lane_mask;
   assign dout      = dout_q;
   assign oe        = (st_q == ST_HOLD) && dir;

   // R5: a single access per strobe
   assert_one_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |=> !(mem_we || mem_re));

   // R5: request withdrawn right after an access
   assert_req_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |=> !req);

   // R4: read data is driven only while a read strobe is being serviced
   assert_oe_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> $past(mem_re));

endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
   import pdma_pkg::*;
#(
   parameter int BUS_W  = 16,
   parameter int ADDR_W = 32,
   parameter int CFG_AW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [BUS_W-1:0]  cfg_wdata,
   output logic [BUS_W-1:0]  cfg_rdata,
   output logic              per_req,
   input  logic              per_wr_n,
   input  logic              per_rd_n,
   input  logic [BUS_W-1:0]  per_din,
   output logic [BUS_W-1:0]  per_dout,
   output logic              per_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic              mem_re,
   output logic [BUS_W-1:0]  mem_wdata,
   input  logic [BUS_W-1:0]  mem_rdata,
   output logic              irq
);

   localparam int HALF_W = BUS_W / 2;

   pdma_ctrl_t        ctrl;
   logic [ADDR_W-1:0] start_addr, stop_addr;
   logic              load, advance, done, last;

   pdma_regs #(
      .REG_W  (BUS_W),
      .ADDR_W (ADDR_W),
      .CFG_AW (CFG_AW)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .done       (done),
      .ctrl       (ctrl),
      .start_addr (start_addr),
      .stop_addr  (stop_addr),
      .irq        (irq)
   );

   pdma_addr_ctr #(
      .ADDR_W (ADDR_W)
   ) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .advance    (advance),
      .wide       (ctrl.wide),
      .start_addr (start_addr),
      .stop_addr  (stop_addr),
      .addr       (mem_addr),
      .last       (last)
   );

   pdma_hs_fsm #(
      .BUS_W (BUS_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (ctrl.en),
      .dir       (ctrl.dir),
      .wide      (ctrl.wide),
      .last      (last),
      .wr_n      (per_wr_n),
      .rd_n      (per_rd_n),
      .din       (per_din),
      .mem_rdata (mem_rdata),
      .req       (per_req),
      .load      (load),
      .advance   (advance),
      .done      (done),
      .mem_we    (mem_we),
      .mem_re    (mem_re),
      .mem_wdata (mem_wdata),
      .dout      (per_dout),
      .oe        (per_oe)
   );

   // R2: no request while the run is off
   assert_req_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.en |-> !per_req);

   // R10: no memory access while the run is off
   assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.en |-> !(mem_we || mem_re));

   // R9: upper byte stays zero in narrow mode
   assert_narrow_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !ctrl.wide) |-> (mem_wdata[BUS_W-1:HALF_W] == '0));

   // R7: a finished run drops its own enable
   assert_done_clears_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !ctrl.en);

endmodule

// File: tb/pdma_engine_test.sv
module pdma_engine_test;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        is_rd;
      logic [31:0] addr;
      logic [15:0] data;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        per_req;
   logic        per_wr_n = 1'b1;
   logic        per_rd_n = 1'b1;
   logic [15:0] per_din = '0;
   logic [15:0] per_dout;
   logic        per_oe;
   logic [31:0] mem_addr;
   logic        mem_we, mem_re;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata;
   logic        irq;

   int   n_checks = 0;
   int   n_fail   = 0;
   bit   finished = 1'b0;
   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [15:0] mem_model(input logic [31:0] a);
      return a[15:0] ^ 16'hC35A;
   endfunction

   assign mem_rdata = mem_model(mem_addr);

   pdma_engine uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .per_req(per_req),
      .per_wr_n(per_wr_n), .per_rd_n(per_rd_n), .per_din(per_din),
      .per_dout(per_dout), .per_oe(per_oe), .mem_addr(mem_addr),
      .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .irq(irq)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   // monitor: pops the scoreboard on each memory access
   always @(negedge clk) begin
      #3;
      if (rst_n && (mem_we || mem_re)) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "R10 unexpected access", {15'd0, mem_we, mem_addr[15:0]}, 32'd0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(mem_re == e.is_rd, "R3/R4 access kind", {31'd0, mem_re}, {31'd0, e.is_rd});
            check(mem_addr == e.addr, "R6 address", mem_addr, e.addr);
            if (!e.is_rd)
               check(mem_wdata == e.data, "R3/R9 write data", {16'd0, mem_wdata}, {16'd0, e.data});
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      check(1'b0, "watchdog", 32'd0, 32'd1);
      summary();
   end

   task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
      cfg_addr = a;
      #1;
      d = cfg_rdata;
   endtask

   task automatic setup(input logic [31:0] s, input logic [31:0] e);
      reg_wr(3'd1, s[15:0]);
      reg_wr(3'd2, s[31:16]);
      reg_wr(3'd3, e[15:0]);
      reg_wr(3'd4, e[31:16]);
   endtask

   task automatic wait_req();
      for (int i = 0; i < 40 && !per_req; i++) @(negedge clk);
      check(per_req == 1'b1, "R2 request raised", {31'd0, per_req}, 32'd1);
   endtask

   task automatic drive_write(input logic [31:0] a, input logic [15:0] d, input bit wide);
      wait_req();
      sb_q.push_back('{is_rd: 1'b0, addr: a, data: wide ? d : {8'd0, d[7:0]}});
      per_din = d; per_wr_n = 1'b0;
      @(negedge clk);
      check(per_req == 1'b0, "R5 request low in strobe", {31'd0, per_req}, 32'd0);
      @(negedge clk);
      per_wr_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic drive_read(input logic [31:0] a, input bit wide);
      logic [15:0] m;
      wait_req();
      m = mem_model(a);
      sb_q.push_back('{is_rd: 1'b1, addr: a, data: 16'd0});
      per_rd_n = 1'b0;
      @(negedge clk);
      #1;
      check(per_oe == 1'b1, "R4 drive enable", {31'd0, per_oe}, 32'd1);
      check(per_dout == (wide ? m : {8'd0, m[7:0]}), "R4/R9 read data",
            {16'd0, per_dout}, {16'd0, (wide ? m : {8'd0, m[7:0]})});
      @(negedge clk);
      per_rd_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic expect_done(input bit want_irq);
      logic [15:0] r;
      reg_rd(3'd0, r);
      check(r[0] == 1'b0, "R7 enable self-clears", {16'd0, r}, 32'd0);
      check(per_req == 1'b0, "R7 request stays low", {31'd0, per_req}, 32'd0);
      check(irq == want_irq, "R8 interrupt level", {31'd0, irq}, {31'd0, want_irq});
   endtask

   initial begin
      logic [15:0] r;
      repeat (3) @(negedge clk);
      check(per_req == 1'b0 && irq == 1'b0 && mem_we == 1'b0, "R2 reset outputs",
            {29'd0, per_req, irq, mem_we}, 32'd0);
      rst_n = 1'b1;
      reg_rd(3'd0, r);
      check(r == 16'd0, "R1 control reset", {16'd0, r}, 32'd0);

      // R1 register readback
      setup(32'h1234_5678, 32'h9ABC_DEF0);
      reg_rd(3'd1, r); check(r == 16'h5678, "R1 first low", {16'd0, r}, 32'h5678);
      reg_rd(3'd2, r); check(r == 16'h1234, "R1 first high", {16'd0, r}, 32'h1234);
      reg_rd(3'd3, r); check(r == 16'hDEF0, "R1 last low", {16'd0, r}, 32'hDEF0);
      reg_rd(3'd4, r); check(r == 16'h9ABC, "R1 last high", {16'd0, r}, 32'h9ABC);

      // R10: strobe while disabled is ignored
      @(negedge clk);
      per_wr_n = 1'b0;
      repeat (2) @(negedge clk);
      check(per_req == 1'b0 && mem_we == 1'b0, "R10 strobe while off",
            {30'd0, per_req, mem_we}, 32'd0);
      per_wr_n = 1'b1;

      // 16-bit write run, interrupts on: R3 R6 R7 R8
      setup(32'h0001_0010, 32'h0001_0014);
      reg_wr(3'd0, 16'h000D);
      drive_write(32'h0001_0010, 16'hBEEF, 1'b1);
      drive_write(32'h0001_0012, 16'h1357, 1'b1);
      drive_write(32'h0001_0014, 16'hF00D, 1'b1);
      expect_done(1'b1);
      repeat (3) @(negedge clk);
      check(irq == 1'b1, "R8 pending holds", {31'd0, irq}, 32'd1);
      reg_wr(3'd0, 16'h0010);
      #1;
      check(irq == 1'b0, "R8 write-1 clears", {31'd0, irq}, 32'd0);

      // 8-bit read run, interrupts off: R4 R6 R9 R8
      setup(32'h0000_2000, 32'h0000_2002);
      reg_wr(3'd0, 16'h0003);
      drive_read(32'h0000_2000, 1'b0);
      drive_read(32'h0000_2001, 1'b0);
      drive_read(32'h0000_2002, 1'b0);
      expect_done(1'b0);

      // 8-bit write, single word, upper bus bits dropped: R9 R7
      setup(32'h0000_0040, 32'h0000_0040);
      reg_wr(3'd0, 16'h0001);
      drive_write(32'h0000_0040, 16'hABCD, 1'b0);
      expect_done(1'b0);

      // R10: wrong-kind strobe ignored, then 16-bit read run
      setup(32'h0000_0100, 32'h0000_0102);
      reg_wr(3'd0, 16'h0007);
      wait_req();
      per_wr_n = 1'b0;
      repeat (2) @(negedge clk);
      check(per_req == 1'b1 && mem_we == 1'b0, "R10 wrong-kind strobe",
            {30'd0, per_req, mem_we}, 32'd2);
      per_wr_n = 1'b1;
      drive_read(32'h0000_0100, 1'b1);
      drive_read(32'h0000_0102, 1'b1);
      expect_done(1'b0);

      // software disable mid-run drops request: R2
      setup(32'h0000_0200, 32'h0000_0210);
      reg_wr(3'd0, 16'h0005);
      wait_req();
      reg_wr(3'd0, 16'h0000);
      check(per_req == 1'b0, "R2 request off after disable", {31'd0, per_req}, 32'd0);

      repeat (4) @(negedge clk);
      check(sb_q.size() == 0, "R5 all accesses seen", sb_q.size(), 32'd0);
      summary();
   end

endmodule